// File: doc/BRIEF.md
# Parallel-Bus LED and Pushbutton Port Controller

This block sits on the peripheral side of an asynchronous parallel host bus. The bus has an address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write enable. The block holds a bank of LED output registers that the host sets by write cycles. It also returns the state of a bank of pushbuttons when the host performs read cycles. Both banks are split into byte lanes, and the lane is chosen by the bus address.

A write follows a fixed order. Output enable stays high and chip select goes low. Write enable then goes low while address and data are presented. Write enable returns high, and after that chip select returns high. The block runs on its own clock. It passes the strobes, the address, the data and the buttons through synchronizer stages. It commits a write when it sees the synchronized write enable leave its asserted level while chip select is still asserted. Reads are combinational from the bus strobes and address, which gives the host a short access time. The block drives the data bus only during a true read, so the host and the block never drive the bus at the same time.

Top module: `pbus_io_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every LED output is 0.
- R2: A write cycle to address 0 sets LED bits [7:0] to the written byte and leaves bits [15:8] unchanged.
- R3: A write cycle to address 1 sets LED bits [15:8] to the written byte and leaves bits [7:0] unchanged. No single clock cycle changes more than one LED byte lane.
- R4: A write cycle to any address of 2 or above leaves all LED outputs unchanged.
- R5: A write-enable pulse while chip select is deasserted (high) leaves all LED outputs unchanged.
- R6: A read with chip select and output enable low, write enable high and address 0 drives the synchronized pushbutton bits [7:0] onto the data bus. Pushbutton changes reach the bus within SYNC_STAGES+1 clocks.
- R7: A read at address 1 drives pushbutton bits [15:8] onto the data bus.
- R8: A read at any address of 2 or above drives 0x00 onto the data bus.
- R9: The block drives the data bus only while chip select and output enable are low and write enable is high. A cycle with write enable low and output enable low acts as a write, and the host's data is taken without contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Host address |
| bus_data | inout | DATA_W (8) | Bidirectional host data |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| led_o | output | LANES*DATA_W (16) | LED drive, bit 0 is lane 0 bit 0 |
| btn_i | input | LANES*DATA_W (16) | Pushbutton inputs, asynchronous |

## Verification
The assertions assume that the host keeps to the write order. Chip select must be asserted before write enable falls and must stay asserted for at least SYNC_STAGES+1 clocks after write enable rises. Address and data must be held over the same window. The bench's write task holds each of these phases for several clocks. The random mix only chooses the address, the data, the button pattern and whether output enable is low during a write. Output enable is always raised before write enable rises, so a write cycle never turns into a read partway through.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   // bus strobes converted to active-high "asserted" form
   typedef struct packed {
      logic cs;
      logic oe;
      logic we;
   } strobe_t;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("pbus_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pbus_wr_capture.sv
module pbus_wr_capture #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  pbus_pkg::strobe_t       stb_s,
   input  logic [ADDR_W-1:0]       addr_s,
   input  logic [DATA_W-1:0]       data_s,
   output logic [LANES*DATA_W-1:0] led_o
);
   logic we_q;
   logic commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b0;
      else        we_q <= stb_s.we;
   end

   // write enable released while chip select still held
   assign commit = we_q & ~stb_s.we & stb_s.cs;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               led_o[g*DATA_W +: DATA_W] <= '0;
            else if (commit && addr_s == LANE_ADDR)
               led_o[g*DATA_W +: DATA_W] <= data_s;
         end
      end
   endgenerate
endmodule

// File: rtl/pbus_rd_path.sv
module pbus_rd_path #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LANES  = 2
) (
   input  pbus_pkg::strobe_t       stb_raw,
   input  logic [ADDR_W-1:0]       addr_raw,
   input  logic [LANES*DATA_W-1:0] btn_s,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    drv_en
);
   logic [DATA_W-1:0] lane_sel [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_sel
         localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(g);
         assign lane_sel[g] = (addr_raw == LANE_ADDR) ? btn_s[g*DATA_W +: DATA_W] : '0;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < LANES; i++) rd_data = rd_data | lane_sel[i];
   end

   // a write-enable low cycle is always a write, never a read
   assign drv_en = stb_raw.cs & stb_raw.oe & ~stb_raw.we;
endmodule

// File: rtl/pbus_io_ctrl.sv
module pbus_io_ctrl #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int LANES       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   inout  wire  [DATA_W-1:0]       bus_data,
   input  logic                    bus_cs_n,
   input  logic                    bus_oe_n,
   input  logic                    bus_we_n,
   output logic [LANES*DATA_W-1:0] led_o,
   input  logic [LANES*DATA_W-1:0] btn_i
);
   import pbus_pkg::*;

   localparam int BTN_W = LANES * DATA_W;
   localparam int AD_W  = ADDR_W + DATA_W;

   generate
      if (LANES < 1 || LANES > (1 << ADDR_W)) begin : g_bad_lanes
         $error("pbus_io_ctrl: LANES must fit the address space");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("pbus_io_ctrl: DATA_W must be positive");
      end
   endgenerate

   strobe_t           stb_raw;
   strobe_t           stb_s;
   logic [AD_W-1:0]   ad_s;
   logic [BTN_W-1:0]  btn_s;
   logic [DATA_W-1:0] rd_data;
   logic              rd_drv_en;

   assign stb_raw = '{cs: ~bus_cs_n, oe: ~bus_oe_n, we: ~bus_we_n};

   pbus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d_i(stb_raw), .q_o(stb_s));

   pbus_sync #(.W(AD_W), .STAGES(SYNC_STAGES)) u_ad_sync (
      .clk(clk), .rst_n(rst_n), .d_i({bus_addr, bus_data}), .q_o(ad_s));

   pbus_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(btn_s));

   pbus_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
      .clk(clk), .rst_n(rst_n), .stb_s(stb_s),
      .addr_s(ad_s[AD_W-1:DATA_W]), .data_s(ad_s[DATA_W-1:0]), .led_o(led_o));

   pbus_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_rd (
      .stb_raw(stb_raw), .addr_raw(bus_addr), .btn_s(btn_s),
      .rd_data(rd_data), .drv_en(rd_drv_en));

   assign bus_data = rd_drv_en ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/pbus_io_chk.sv
module pbus_io_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LANES  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic                    bus_cs_n,
   input logic                    bus_oe_n,
   input logic                    bus_we_n,
   input logic [LANES*DATA_W-1:0] led_o,
   input logic                    drv_en,
   input logic [DATA_W-1:0]       rd_data,
   input logic                    cs_s
);
   localparam logic [ADDR_W:0] LANE_LIMIT = (ADDR_W+1)'(LANES);

   logic [LANES*DATA_W-1:0] led_prev;
   logic [LANES-1:0]        lane_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_prev <= '0;
      else        led_prev <= led_o;
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_chg
         assign lane_chg[g] = led_o[g*DATA_W +: DATA_W] != led_prev[g*DATA_W +: DATA_W];
      end
   endgenerate

   always @(negedge clk) begin
      if (!rst_n) assert_led_reset_R1: assert (led_o == '0);
   end

   assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_chg));

   assert_led_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (led_o != $past(led_o)) |-> $past(cs_s));

   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && {1'b0, bus_addr} >= LANE_LIMIT) |-> rd_data == '0);

   assert_no_drive_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> !drv_en);

   assert_no_drive_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n || bus_oe_n) |-> !drv_en);
endmodule

bind pbus_io_ctrl pbus_io_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
   .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .led_o(led_o),
   .drv_en(rd_drv_en), .rd_data(rd_data), .cs_s(stb_s.cs));

// File: tb/sim_pbus_io_ctrl.sv
module sim_pbus_io_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] btn = '0;
   logic [15:0] led;
   logic        drv = 1'b0;
   logic [7:0]  drv_val = '0;
   wire  [7:0]  bus;
   int checks = 0, failures = 0;
   logic done = 1'b0;
   logic [15:0] led_model = '0;

   assign bus = drv ? drv_val : 8'bz;

   always #2 clk = ~clk;

   pbus_io_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_data(bus),
      .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
      .led_o(led), .btn_i(btn));

   function automatic logic [15:0] next_led(logic [15:0] cur, logic [3:0] a, logic [7:0] d);
      logic [15:0] r = cur;
      if (a == 4'd0) r[7:0] = d;
      else if (a == 4'd1) r[15:8] = d;
      return r;
   endfunction

   function automatic logic [7:0] read_val(logic [15:0] b, logic [3:0] a);
      if (a == 4'd0) return b[7:0];
      if (a == 4'd1) return b[15:8];
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d, bit oe_low);
      @(negedge clk); cs_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
      repeat (2) @(negedge clk);
      addr = a; drv = 1'b1; drv_val = d; we_n = 1'b0;
      repeat (3) @(negedge clk);
      oe_n = 1'b1;
      @(negedge clk); we_n = 1'b1;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; drv = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(logic [3:0] a, string tag);
      repeat (4) @(negedge clk);
      addr = a; cs_n = 1'b0; oe_n = 1'b0;
      #1;
      check(tag, {8'h00, bus}, {8'h00, read_val(btn, a)});
      @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 in reset", led, 16'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", led, 16'h0);

      bus_write(4'd0, 8'hA5, 1'b0); led_model = next_led(led_model, 4'd0, 8'hA5);
      check("R2 low lane", led, led_model);
      bus_write(4'd1, 8'h3C, 1'b0); led_model = next_led(led_model, 4'd1, 8'h3C);
      check("R3 high lane", led, led_model);
      bus_write(4'd2, 8'hFF, 1'b0);
      check("R4 unmapped 2", led, led_model);
      bus_write(4'd15, 8'h00, 1'b0);
      check("R4 unmapped 15", led, led_model);

      // write-enable pulse with chip select idle
      @(negedge clk); addr = 4'd0; drv = 1'b1; drv_val = 8'h11; we_n = 1'b0;
      repeat (4) @(negedge clk); we_n = 1'b1;
      repeat (5) @(negedge clk); drv = 1'b0;
      check("R5 no cs", led, led_model);

      bus_write(4'd0, 8'h5A, 1'b1); led_model = next_led(led_model, 4'd0, 8'h5A);
      check("R9 oe low write", led, led_model);

      btn = 16'hBEEF;
      bus_read(4'd0, "R6 low buttons");
      bus_read(4'd1, "R7 high buttons");
      bus_read(4'd3, "R8 unmapped read");
      btn = 16'h0180;
      bus_read(4'd0, "R6 low buttons 2");
      bus_read(4'd1, "R7 high buttons 2");

      for (int i = 0; i < 60; i++) begin
         logic [3:0] a = 4'($urandom_range(0, 3));
         if ($urandom_range(0, 1) == 0) begin
            logic [7:0] d = 8'($urandom);
            bus_write(a, d, $urandom_range(0, 1) == 1);
            led_model = next_led(led_model, a, d);
            check("R2 R3 R4 random write", led, led_model);
         end else begin
            btn = 16'($urandom);
            bus_read(a, "R6 R7 R8 random read");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule